// File: doc/BRIEF.md
# Segment Drive Line Loader

This block collects one display line for a bank of liquid crystal segment outputs and holds it on per-segment drive-select outputs. Display bits come in on a small data bus, paced by an external data strobe. In the wide mode each strobe brings four bits. In the narrow mode each strobe brings a single bit on bus lane 0. A direction input sets the end of the bank where a line starts to fill. A separate latch strobe commits the collected line to the output register and rewinds the fill pointer for the next line. A blanking input drives every output to the non-select level at once.

The strobes are sampled by the system clock `clk`, and each one acts on its falling edge as seen at a clock edge. A line of 120 segments takes 30 strobes in wide mode or 120 in narrow mode. Strobes that arrive after the line is full have no effect until the next latch. The asynchronous active-low reset is released in step with `clk`. It empties the line, rewinds the pointer and sets every output to non-select.

Top module: `seg_line_loader`

## Requirements
- R1: While reset is low, and after it is released, every `seg_sel` bit is 0 (non-select) and the next strobe fills the first position. A reset in the middle of a line discards the partial line.
- R2: Load state changes only on a falling edge of `dclk` (1 then 0 on consecutive clock edges). `din` values present while `dclk` is high or steady have no effect. Only the value present at the falling edge is taken.
- R3: With `par_mode` = 1 (wide), each `dclk` falling edge loads four bits `din[3:0]` into four consecutive positions, and 30 strobes fill the 120-segment line.
- R4: With `par_mode` = 0 (narrow), each `dclk` falling edge loads only `din[0]` into one position. `din[3:1]` are ignored, and 120 strobes fill the line.
- R5: With `fill_up` = 1, the first loaded bit goes to segment 0 and later bits go to rising segment numbers. With `fill_up` = 0, the first bit goes to segment 119 and later bits go to falling segment numbers.
- R6: Within a wide-mode nibble, `din[0]` goes to the position that is filled first, and `din[1]`, `din[2]`, `din[3]` follow in the fill direction.
- R7: A falling edge of `lp` copies the loaded line to the output register, with `seg_sel[i]` = 1 meaning segment i is selected. Between latch edges, `seg_sel` keeps its value while new data is loaded.
- R8: A falling edge of `lp` rewinds the fill pointer, so the next line starts at the end chosen by `fill_up`, even if the previous line was only partly loaded. Positions that were not loaded keep their old line contents.
- R9: Once the line is full, further `dclk` falling edges change nothing until the next `lp` falling edge.
- R10: While `disp_off` = 1, every `seg_sel` bit is 0 whatever the latched data holds. When `disp_off` returns to 0, the latched line reappears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Data strobe; acts on its falling edge |
| lp | input | 1 | Latch strobe; acts on its falling edge |
| par_mode | input | 1 | 1 = four bits per strobe, 0 = one bit per strobe |
| fill_up | input | 1 | 1 = fill from segment 0 upward, 0 = from segment 119 downward |
| disp_off | input | 1 | 1 = force all outputs to non-select |
| din | input | 4 | Display data bus |
| seg_sel | output | 120 | Per-segment drive select, 1 = select |

## Verification
The bench loads full lines in both modes and both directions with patterns that differ from nibble to nibble. A design that reversed the nibble lanes or the fill direction would show the pattern mirrored or scrambled. It overfills a line with contrasting data, which a design with no full stop would let overwrite the last positions or wrap. It latches a partial line and then loads one more strobe: a design that failed to rewind would place that strobe in the middle of the bank. It also checks that `din` wiggles while `dclk` is high are dropped, that a blanking period hides the line and then brings it back, and that a reset in the middle of a line clears both the outputs and the pointer.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } load_mode_e;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/seg_edge_det.sv
module seg_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  assign fall = prev_q & ~sig;
endmodule

// File: rtl/seg_shift_load.sv
module seg_shift_load
  import seg_loader_pkg::*;
#(
  parameter int NSEG = 120,
  parameter int PW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dclk_fall,
  input  logic            lp_fall,
  input  load_mode_e      mode,
  input  logic            fill_up,
  input  logic [PW-1:0]   din,
  output logic [NSEG-1:0] line_q
);
  localparam int CW = $clog2(NSEG + 1);

  logic [CW-1:0]   fill_q, fill_d;
  logic [NSEG-1:0] line_d;
  logic            full, load_en;
  int              fill_i, step_w, sum_w;

  assign full    = (fill_q == CW'(NSEG));
  assign load_en = dclk_fall && !lp_fall && !full;
  assign fill_i  = int'(fill_q);
  assign step_w  = (mode == MODE_PARALLEL) ? PW : 1;
  assign sum_w   = fill_i + step_w;

  // next pointer: rewind on latch, advance with saturation on a strobe
  always_comb begin
    fill_d = fill_q;
    if (lp_fall)      fill_d = '0;
    else if (load_en) fill_d = (sum_w > NSEG) ? CW'(NSEG) : CW'(sum_w);
  end

  // next line: lane k lands k places past the pointer in the fill direction
  always_comb begin
    line_d = line_q;
    if (load_en) begin
      for (int i = 0; i < NSEG; i++) begin
        for (int k = 0; k < PW; k++) begin
          if (k < step_w &&
              (fill_up ? (i - fill_i) : (NSEG - 1 - fill_i - i)) == k)
            line_d[i] = din[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      line_q <= '0;
    end else begin
      fill_q <= fill_d;
      if (load_en) line_q <= line_d;
    end
  end

  p_hold_no_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dclk_fall && !lp_fall) |=> ($stable(fill_q) && $stable(line_q)));

  p_par_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_fall && !lp_fall && mode == MODE_PARALLEL && fill_q <= CW'(NSEG - PW))
    |=> (fill_q == $past(fill_q) + CW'(PW)));

  p_ser_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_fall && !lp_fall && mode == MODE_SERIAL && !full)
    |=> (fill_q == $past(fill_q) + CW'(1)));

  p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fall |=> (fill_q == '0));

  p_full_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !lp_fall) |=> ($stable(line_q) && $stable(fill_q)));

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(NSEG));
endmodule

// File: rtl/seg_out_latch.sv
module seg_out_latch #(
  parameter int NSEG = 120
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lp_fall,
  input  logic            disp_off,
  input  logic [NSEG-1:0] line_q,
  output logic [NSEG-1:0] seg_sel
);
  logic [NSEG-1:0] out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (lp_fall) out_d = line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign seg_sel = disp_off ? '0 : out_q;

  p_latch_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fall |=> (out_q == $past(line_q)));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_fall |=> $stable(out_q));
endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader
  import seg_loader_pkg::*;
#(
  parameter int NSEG = 120,
  parameter int PW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dclk,
  input  logic            lp,
  input  logic            par_mode,
  input  logic            fill_up,
  input  logic            disp_off,
  input  logic [PW-1:0]   din,
  output logic [NSEG-1:0] seg_sel
);
  logic            rst_n_s;
  logic [1:0]      falls;
  logic [NSEG-1:0] line_q;
  load_mode_e      mode;

  assign mode = load_mode_e'(par_mode);

  seg_rst_sync u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  seg_edge_det #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n_s), .sig({lp, dclk}), .fall(falls)
  );

  seg_shift_load #(.NSEG(NSEG), .PW(PW)) u_load (
    .clk(clk), .rst_n(rst_n_s), .dclk_fall(falls[0]), .lp_fall(falls[1]),
    .mode(mode), .fill_up(fill_up), .din(din), .line_q(line_q)
  );

  seg_out_latch #(.NSEG(NSEG)) u_out (
    .clk(clk), .rst_n(rst_n_s), .lp_fall(falls[1]), .disp_off(disp_off),
    .line_q(line_q), .seg_sel(seg_sel)
  );
endmodule

// File: tb/seg_line_loader_test.sv
module seg_line_loader_test;
  logic         clk = 1'b0;
  logic         rst_n, dclk, lp, par_mode, fill_up, disp_off;
  logic [3:0]   din;
  logic [119:0] seg_sel;

  always #10 clk = ~clk;

  seg_line_loader uut (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .lp(lp), .par_mode(par_mode),
    .fill_up(fill_up), .disp_off(disp_off), .din(din), .seg_sel(seg_sel)
  );

  int           n_tests = 0;
  int           n_fail  = 0;
  bit [119:0]   mline;
  int           mfill;
  bit [119:0]   last_exp;
  bit [119:0]   exp_q[$];
  string        tag_q[$];

  task automatic check(string req, logic [119:0] act, logic [119:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  function automatic bit [3:0] pat(int i, int s);
    return 4'((i * s + 3) % 16);
  endfunction

  // reference: place the bits taken at one falling strobe
  task automatic model_take(bit [3:0] d, bit par, bit up);
    int step = par ? 4 : 1;
    if (mfill < 120) begin
      for (int k = 0; k < step; k++) begin
        int idx = up ? (mfill + k) : (119 - mfill - k);
        if (idx >= 0 && idx < 120) mline[idx] = d[k];
      end
      mfill = (mfill + step > 120) ? 120 : mfill + step;
    end
  endtask

  task automatic send(bit [3:0] d, bit par, bit up);
    @(negedge clk);
    par_mode = par; fill_up = up; din = d; dclk = 1'b1;
    @(negedge clk);
    dclk = 1'b0;
    @(negedge clk);
    model_take(d, par, up);
  endtask

  // latch and hand the expected line to the monitor
  task automatic latch(string tag);
    @(negedge clk); lp = 1'b1;
    @(negedge clk); lp = 1'b0;
    exp_q.push_back(mline);
    tag_q.push_back(tag);
    last_exp = mline;
    mfill = 0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: compares each committed line once it is visible
  initial begin
    forever begin
      bit [119:0] e;
      string      t;
      wait (exp_q.size() != 0);
      repeat (2) @(negedge clk);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, seg_sel, e);
    end
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; dclk = 1'b0; lp = 1'b0; par_mode = 1'b1;
    fill_up = 1'b1; disp_off = 1'b0; din = 4'h0;
    mline = '0; mfill = 0; last_exp = '0;
    repeat (5) @(negedge clk);
    check("R1 outputs in reset", seg_sel, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 outputs after reset", seg_sel, '0);

    // wide mode, ascending
    for (int i = 0; i < 30; i++) send(pat(i, 7), 1'b1, 1'b1);
    latch("R3 R5 wide ascending line");
    check("R6 first nibble lanes ascending", {116'd0, seg_sel[3:0]},
          {116'd0, pat(0, 7)});

    // wide mode, descending
    for (int i = 0; i < 30; i++) send(pat(i, 5), 1'b1, 1'b0);
    latch("R5 R6 wide descending line");
    check("R6 first nibble lanes descending",
          {116'd0, seg_sel[116], seg_sel[117], seg_sel[118], seg_sel[119]},
          {116'd0, pat(0, 5)});

    // narrow mode, ascending, upper lanes carry noise
    for (int i = 0; i < 120; i++)
      send({3'(i * 3 + 1), 1'((i / 3) % 2 ^ (i % 5 == 0))}, 1'b0, 1'b1);
    latch("R4 narrow ascending line");

    // narrow mode, descending
    for (int i = 0; i < 120; i++)
      send({3'(~i), 1'((i % 7) < 3)}, 1'b0, 1'b0);
    latch("R4 R5 narrow descending line");

    // hold between latches, then overfill
    for (int i = 0; i < 30; i++) send(4'hA, 1'b1, 1'b1);
    check("R7 outputs hold before latch", seg_sel, last_exp);
    for (int i = 0; i < 3; i++) send(4'h5, 1'b1, 1'b1);
    latch("R9 strobes after full ignored");
    for (int i = 0; i < 120; i++) send(4'hF, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) send(4'h0, 1'b0, 1'b0);
    latch("R9 narrow overfill ignored");

    // partial line, then rewind
    for (int i = 0; i < 5; i++) send(4'h0, 1'b1, 1'b1);
    latch("R8 partial line keeps old tail");
    send(4'h9, 1'b1, 1'b0);
    latch("R8 pointer rewound to top end");
    check("R8 top nibble after rewind",
          {116'd0, seg_sel[116], seg_sel[117], seg_sel[118], seg_sel[119]},
          {116'd0, 4'h9});

    // data changes while the strobe is high are dropped
    @(negedge clk); par_mode = 1'b1; fill_up = 1'b1; din = 4'h3; dclk = 1'b1;
    @(negedge clk); din = 4'hC;
    @(negedge clk); din = 4'h7;
    @(negedge clk); din = 4'h6; dclk = 1'b0;
    @(negedge clk);
    model_take(4'h6, 1'b1, 1'b1);
    repeat (3) @(negedge clk) din = ~din;
    latch("R2 only value at falling edge taken");

    // blanking
    @(negedge clk); disp_off = 1'b1;
    @(negedge clk);
    check("R10 blanked outputs", seg_sel, '0);
    @(negedge clk); disp_off = 1'b0;
    @(negedge clk);
    check("R10 line restored after blanking", seg_sel, last_exp);

    // reset in the middle of a line
    for (int i = 0; i < 3; i++) send(4'hF, 1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-line clears outputs", seg_sel, '0);
    rst_n = 1'b1;
    mline = '0; mfill = 0;
    repeat (3) @(negedge clk);
    send(4'h9, 1'b1, 1'b1);
    latch("R1 line restarts after reset");

    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
    report();
    $finish;
  end
endmodule